// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer mapped on a simple 32-bit register bus. Software programs a tick divider and a timeout length in ticks, then sets an enable bit. From that point a countdown runs. If software does not write a keep-alive word in time, the countdown expires. The block then raises a one-cycle system reset request and records the event in a sticky cause flag.

The cause flag is cleared only by the power-on reset or by software. The ordinary system reset, which the request itself brings about, leaves the flag alone. Boot code can therefore tell whether the last reset came from the watchdog. All other state returns to its defaults on either reset.

The bus is a plain single-cycle register port with no back-pressure. A write is taken on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational and is valid while `bus_en` is high and `bus_we` is low.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads 0x00000000, the load word reads 0x0000FFFF, and `sys_rst_req` is low.
- R2: The control word (offset 0x20) holds the run bit at bit 7 and the 16-bit tick divider at bits 31:16. Its other bits always read zero.
- R3: The load word (offset 0x24) keeps only bits 15:0. Bits 31:16 read zero.
- R4: Suppose a write sets the run bit while it is clear, with load L and divider P. Then `sys_rst_req` is high for one cycle right after the (L·P)-th rising edge that follows the write edge. It then repeats every L·P cycles, using the value held in the load word at each reload.
- R5: A write to offset 0x00 with bit 9 set restarts both the countdown and the tick divider from the load word. A write to 0x00 with bit 9 clear has no effect.
- R6: Writing the load word does not disturb a countdown in progress. The new value first applies at the next reload.
- R7: Clearing the run bit stops the countdown, and no request is raised. Setting the run bit again starts a full period.
- R8: The cause flag (bit 1 at offset 0x38) is set on the edge that raises the request. It survives `rst_n` and is cleared by `por_n`.
- R9: Writing 1 to bit 1 at offset 0x38 clears the cause flag. Writing 0 there leaves the flag unchanged.
- R10: Reads from offsets other than 0x20, 0x24 and 0x38 return zero. Writes to such offsets change nothing.
- R11: A divider value of 0 behaves as 1, meaning one tick per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low, clears everything except the cause flag |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is the cause flag surviving the reset it produced. The bench first lets a countdown expire. It then pulses only `rst_n` and reads the flag back, before clearing it by write and finally by `por_n`. Keep-alive and load writes are placed a known number of cycles inside a running period. This checks that a restart moves the next request by exactly one full period, and that a load write moves nothing until the following reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int DIV_W    = 16;
  localparam int LOAD_W   = 16;
  localparam int DIV_LSB  = 16;
  localparam int RUN_BIT  = 7;
  localparam int KICK_BIT = 9;
  localparam int CAUSE_BIT = 1;

  localparam logic [ADDR_W-1:0] OFS_KICK  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h38;

  localparam logic [LOAD_W-1:0] LOAD_RST = '1;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run,
  output logic [DIV_W-1:0]  divider,
  output logic [LOAD_W-1:0] load_val,
  output logic              reload,
  output logic              cause
);
  logic wr_ctrl, wr_load, wr_kick, wr_cause;

  assign wr_ctrl  = bus_en && bus_we && (bus_addr == OFS_CTRL);
  assign wr_load  = bus_en && bus_we && (bus_addr == OFS_LOAD);
  assign wr_kick  = bus_en && bus_we && (bus_addr == OFS_KICK);
  assign wr_cause = bus_en && bus_we && (bus_addr == OFS_CAUSE);

  assign reload = (wr_kick && bus_wdata[KICK_BIT])
                | (wr_ctrl && bus_wdata[RUN_BIT] && !run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      divider  <= '0;
      load_val <= LOAD_RST;
    end else begin
      if (wr_ctrl) begin
        run     <= bus_wdata[RUN_BIT];
        divider <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (wr_load) load_val <= bus_wdata[LOAD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cause <= 1'b0;
    else if (expire) cause <= 1'b1;
    else if (wr_cause && bus_wdata[CAUSE_BIT]) cause <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_CTRL: begin
          bus_rdata[DIV_LSB +: DIV_W] = divider;
          bus_rdata[RUN_BIT]          = run;
        end
        OFS_LOAD:  bus_rdata[LOAD_W-1:0] = load_val;
        OFS_CAUSE: bus_rdata[CAUSE_BIT]  = cause;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] divider,
  output logic             tick,
  output logic [DIV_W-1:0] phase
);
  logic last;

  assign last = (divider <= DIV_W'(1)) || (phase == divider - DIV_W'(1));
  assign tick = run && !clr && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (!run || clr || last) phase <= '0;
    else                        phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              tick,
  input  logic [LOAD_W-1:0] load_val,
  output logic              expire,
  output logic              req,
  output logic [LOAD_W-1:0] count
);
  assign expire = tick && !reload && (count <= LOAD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
      req   <= 1'b0;
    end else begin
      req <= expire;
      if (reload || expire) count <= load_val;
      else if (tick)        count <= count - LOAD_W'(1);
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_req
);
  logic              run, reload, cause, tick, expire;
  logic [DIV_W-1:0]  divider, phase;
  logic [LOAD_W-1:0] load_val, count;
  logic              rst_all_n;

  assign rst_all_n = rst_n && por_n;

  wdt_regfile u_regs (
    .clk(clk), .rst_n(rst_all_n), .por_n(por_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .expire(expire), .bus_rdata(bus_rdata), .run(run), .divider(divider),
    .load_val(load_val), .reload(reload), .cause(cause)
  );

  wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_all_n), .run(run), .clr(reload),
    .divider(divider), .tick(tick), .phase(phase)
  );

  wdt_countdown #(.LOAD_W(LOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_all_n), .reload(reload), .tick(tick),
    .load_val(load_val), .expire(expire), .req(sys_rst_req), .count(count)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              sys_rst_req,
  input logic              run,
  input logic              reload,
  input logic              cause,
  input logic              expire,
  input logic [DIV_W-1:0]  phase,
  input logic [LOAD_W-1:0] load_val,
  input logic [LOAD_W-1:0] count
);
  logic clr_wr;
  assign clr_wr = bus_en && bus_we && (bus_addr == OFS_CAUSE) && bus_wdata[CAUSE_BIT];

  // R4
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sys_rst_req |-> $past(run));

  // R8
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sys_rst_req |-> cause);

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reload |=> (count == $past(load_val)));

  // R7
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !run |=> (phase == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cause && !clr_wr) |=> cause);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_wr && !expire) |=> !cause);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sys_rst_req(sys_rst_req),
  .run(run), .reload(reload), .cause(cause), .expire(expire),
  .phase(phase), .load_val(load_val), .count(count)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  int checks = 0, failures = 0, cyc = 0;
  int expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer u_wdog_timer (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int wc);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    wc = cyc;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
    bus_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare each request against the queued edge number
  always @(negedge clk) begin
    if (por_n && rst_n) begin
      if (sys_rst_req) begin
        if (expq.size() == 0) check(1'b0, "R4 unexpected request", cyc, 0);
        else begin
          int e;
          e = expq.pop_front();
          check(cyc == e, "R4 request cycle", cyc, e);
        end
      end else if (expq.size() > 0 && cyc > expq[0]) begin
        check(1'b0, "R4 missed request", cyc, expq[0]);
        void'(expq.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, w2, k, d;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    // R1
    rd_chk(8'h20, 32'h0, "R1 ctrl reset");
    rd_chk(8'h24, 32'h0000FFFF, "R1 load reset");
    check(sys_rst_req == 1'b0, "R1 request low", sys_rst_req, 0);
    // R2
    wr(8'h20, 32'hFFFF_FF7F, d);
    rd_chk(8'h20, 32'hFFFF_0000, "R2 ctrl readback");
    wr(8'h20, 32'h0, d);
    // R3
    wr(8'h24, 32'h1234_5678, d);
    rd_chk(8'h24, 32'h0000_5678, "R3 load width");
    // R10
    wr(8'h10, 32'hFFFF_FFFF, d);
    rd_chk(8'h10, 32'h0, "R10 unmapped read");
    rd_chk(8'h04, 32'h0, "R10 unmapped read 2");
    rd_chk(8'h20, 32'h0, "R10 ctrl untouched");
    rd_chk(8'h24, 32'h0000_5678, "R10 load untouched");
    // R4: L=5, P=3
    wr(8'h24, 32'd5, d);
    wr(8'h20, 32'h0003_0080, w);
    expq.push_back(w + 15); expq.push_back(w + 30);
    wait_until(w + 33);
    wr(8'h20, 32'h0003_0000, d);
    // R8
    rd_chk(8'h38, 32'h2, "R8 cause set");
    // R5
    wr(8'h20, 32'h0003_0080, w);
    wait_until(w + 7);
    wr(8'h00, 32'h0, d);
    wait_until(w + 11);
    wr(8'h00, 32'h0000_0200, k);
    expq.push_back(k + 15);
    wait_until(k + 17);
    wr(8'h20, 32'h0, d);
    // R6: L=5, P=2, load changed to 20 mid-period
    wr(8'h20, 32'h0002_0080, w);
    expq.push_back(w + 10);
    wait_until(w + 2);
    wr(8'h24, 32'd20, d);
    expq.push_back(w + 50);
    rd_chk(8'h24, 32'd20, "R6 load readback");
    wait_until(w + 52);
    wr(8'h20, 32'h0, d);
    // R7: L=4, P=2, stop before expiry
    wr(8'h24, 32'd4, d);
    wr(8'h20, 32'h0002_0080, w);
    wait_until(w + 4);
    wr(8'h20, 32'h0002_0000, d);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, "R7 nothing pending", expq.size(), 0);
    wr(8'h20, 32'h0002_0080, w2);
    expq.push_back(w2 + 8);
    wait_until(w2 + 10);
    wr(8'h20, 32'h0, d);
    // R8: system reset keeps cause
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_chk(8'h38, 32'h2, "R8 cause survives rst_n");
    rd_chk(8'h20, 32'h0, "R1 ctrl after rst_n");
    rd_chk(8'h24, 32'h0000FFFF, "R1 load after rst_n");
    // R9
    wr(8'h38, 32'h0, d);
    rd_chk(8'h38, 32'h2, "R9 write 0 keeps cause");
    wr(8'h38, 32'h2, d);
    rd_chk(8'h38, 32'h0, "R9 write 1 clears cause");
    // R11: divider 0, L=3
    wr(8'h24, 32'd3, d);
    wr(8'h20, 32'h0000_0080, w);
    expq.push_back(w + 3);
    wait_until(w + 3);
    wr(8'h20, 32'h0, d);
    rd_chk(8'h38, 32'h2, "R11 cause after fast expiry");
    // R8: power-on reset clears cause
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    rd_chk(8'h38, 32'h0, "R8 por clears cause");
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R4 all requests seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule